// File: doc/BRIEF.md
# Reference switchover phase corrector

This block sits in front of the digital PLL of a T1/E1 clock synchronizer. Two reference pulse streams come in, a primary and a secondary, together with a select line. The block routes the selected stream onward as a virtual reference for the PLL. It also watches the PLL feedback pulse stream. Everything is sampled by one fast master clock, and all pulse inputs are assumed to be synchronous to that clock.

When the selection changes and correction is enabled, the block stops emitting pulses. It then counts master-clock cycles from the first rising edge of the newly selected reference to the next rising edge of the feedback. That count, taken modulo the feedback period for the programmed rate, becomes a delay. The delay is applied to every later pulse of the new reference, so the virtual reference stays in phase with the feedback and the PLL sees no phase step.

A clear input, or removing the enable, drops the delay to zero. The selected reference then passes straight through. A reserved rate code silences the output and raises an error flag. The rate select may only change while reset is applied. The block assumes that reference pulses are spaced further apart than the current delay.

Top module: `ref_phase_corrector`

## Requirements
- R1: While reset is asserted, vref_o and rate_err_o are both low.
- R2: With corr_en_i low, a rising edge on the selected reference (use_sec_i=0 selects primary, 1 selects secondary) produces a one-cycle vref_o pulse one clock after the input edge is sampled. Edges on the unselected reference never reach vref_o.
- R3: With corr_en_i low, changing use_sec_i causes no blanking. The first edge of the new reference already passes through with the one-cycle latency.
- R4: With corr_en_i high, vref_o stays low from a selection change until the feedback edge that completes the measurement.
- R5: The measured delay D is the number of clock edges from the first new-reference edge after the switch to the next feedback edge. Every later reference edge then appears on vref_o D+1 clocks after it is sampled.
- R6: D is the gap modulo the feedback period, in master clocks: rate_sel_i 01 uses PER_8K, 10 uses PER_T1 and 11 uses PER_E1.
- R7: A high corr_clr_i sets the delay to zero and aborts any measurement in progress. It takes priority over a measurement that completes in the same cycle.
- R8: With rate_sel_i = 00 (reserved), rate_err_o is high from the next clock and vref_o stays low. Both recover once a valid code returns.
- R9: A new-reference edge that falls in the same cycle as a feedback edge gives D = 0.
- R10: Dropping corr_en_i forces the delay to zero, so the selected reference passes with the one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master sample clock |
| rst_n | input | 1 | synchronous active-low reset |
| pri_ref_i | input | 1 | primary reference pulse stream |
| sec_ref_i | input | 1 | secondary reference pulse stream |
| use_sec_i | input | 1 | 0 selects primary, 1 selects secondary |
| fb_i | input | 1 | feedback pulse stream from the PLL |
| corr_en_i | input | 1 | phase correction enable from the mode controller |
| corr_clr_i | input | 1 | clears the stored delay |
| rate_sel_i | input | 2 | feedback rate code (00 reserved) |
| vref_o | output | 1 | virtual reference pulse to the PLL |
| rate_err_o | output | 1 | reserved rate code in use |

## Verification
A clear and the feedback edge that closes a measurement can fall in the same cycle, and the two demand different delays. The bench provokes this by switching the reference and sending a new-reference edge. It then raises the clear in exactly the cycle that carries the feedback edge, four clocks later. The result is judged at the port: the next reference pulse must come out after one clock, as clear demands, rather than after five, as the completed measurement would give.

// File: rtl/rpc_pkg.sv
// Package: shared types and rate codes for the reference switchover corrector.
// Assumes nothing beyond IEEE 1800-2017.
package rpc_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_MEAS} meter_st_t;

    localparam logic [1:0] RATE_RSVD = 2'b00;
    localparam logic [1:0] RATE_8K   = 2'b01;
    localparam logic [1:0] RATE_T1   = 2'b10;
    localparam logic [1:0] RATE_E1   = 2'b11;
endpackage

// File: rtl/rpc_edge_detect.sv
// Rising-edge detector for a group of pulse inputs.
// Assumes the inputs are already synchronous to clk; one flop per input.
module rpc_edge_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_lane
        // remember last sample of this lane
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= in_i[g];
        end
        assign rise_o[g] = in_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/rpc_phase_meter.sv
// Phase meter: after a reference switch (with correction enabled), counts
// clocks from the first new-reference edge to the next feedback edge, modulo
// the feedback period, and holds the result as the delay. Blanks the output
// from the switch until the measurement ends.
// Assumes period_i >= 1 and stable outside reset.
module rpc_phase_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise_i,
    input  logic             fb_rise_i,
    input  logic             switch_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] delay_o,
    output logic             blank_o
);
    import rpc_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    meter_st_t        state_q;
    logic [CNT_W-1:0] mcnt_q;
    logic [CNT_W-1:0] delay_q;
    logic             start;

    assign start   = switch_i & en_i & ~clr_i;
    assign blank_o = (state_q != ST_RUN) | start;
    assign delay_o = delay_q;

    // measurement state, running count and stored delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mcnt_q  <= '0;
            delay_q <= '0;
        end else if (clr_i || !en_i) begin
            state_q <= ST_RUN;
            delay_q <= '0;
        end else if (switch_i) begin
            state_q <= ST_WAIT;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (ref_rise_i && fb_rise_i) begin
                        delay_q <= '0;
                        state_q <= ST_RUN;
                    end else if (ref_rise_i) begin
                        mcnt_q  <= (period_i == ONE) ? '0 : ONE;
                        state_q <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (fb_rise_i) begin
                        delay_q <= mcnt_q;
                        state_q <= ST_RUN;
                    end else begin
                        mcnt_q <= (mcnt_q == period_i - ONE) ? '0 : mcnt_q + ONE;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // R7: clear leaves a zero delay
    a_r7_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (delay_o == '0) && !blank_o || switch_i && en_i);

    // R10: enable low leaves a zero delay
    a_r10_en_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (delay_o == '0));

    // R6: a completed measurement lands below the period
    a_r6_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEAS && fb_rise_i && en_i && !clr_i && !switch_i)
        |=> (delay_o < $past(period_i)));
endmodule

// File: rtl/rpc_delay_line.sv
// Programmable pulse delay: each selected-reference edge is re-emitted as a
// one-cycle pulse delay_i clocks later, via a single countdown.
// Assumes reference edges are spaced more than delay_i clocks apart (a new
// edge restarts the countdown).
module rpc_delay_line #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic             blank_i,
    input  logic             suppress_i,
    output logic             vref_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             vref_q;

    assign vref_o = vref_q;

    // countdown to the delayed output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            vref_q <= 1'b0;
        end else begin
            vref_q <= 1'b0;
            if (blank_i) begin
                cnt_q <= '0;
            end else if (ref_rise_i) begin
                if (delay_i == '0) vref_q <= ~suppress_i;
                else               cnt_q  <= delay_i;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ONE) vref_q <= ~suppress_i;
            end
        end
    end

    // R4: no pulse while the meter blanks
    a_r4_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> !vref_o);

    // R8: no pulse while the rate code is reserved
    a_r8_suppress_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_i |=> !vref_o);
endmodule

// File: rtl/ref_phase_corrector.sv
// Reference switchover phase corrector (top). Selects primary or secondary
// reference, detects switches, measures phase offset against the feedback
// and delays the new reference so the virtual reference stays in phase.
// Assumes synchronous pulse inputs and rate_sel_i changed only under reset.
module ref_phase_corrector #(
    parameter int PER_8K = 2500,
    parameter int PER_T1 = 13,
    parameter int PER_E1 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_ref_i,
    input  logic       sec_ref_i,
    input  logic       use_sec_i,
    input  logic       fb_i,
    input  logic       corr_en_i,
    input  logic       corr_clr_i,
    input  logic [1:0] rate_sel_i,
    output logic       vref_o,
    output logic       rate_err_o
);
    import rpc_pkg::*;

    localparam int MAX_A   = (PER_8K > PER_T1) ? PER_8K : PER_T1;
    localparam int MAX_PER = (MAX_A > PER_E1) ? MAX_A : PER_E1;
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    logic [2:0]       rise;
    logic             sel_q;
    logic             switch_now;
    logic             ref_rise;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] delay;
    logic             blank;
    logic             rsvd;
    logic             rate_err_q;

    rpc_edge_detect #(.N(3)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({fb_i, sec_ref_i, pri_ref_i}),
        .rise_o(rise)
    );

    assign switch_now = use_sec_i ^ sel_q;
    assign ref_rise   = use_sec_i ? rise[1] : rise[0];
    assign rsvd       = (rate_sel_i == RATE_RSVD);
    assign rate_err_o = rate_err_q;

    // feedback period for the programmed rate
    always_comb begin
        case (rate_sel_i)
            RATE_8K: period = CNT_W'(PER_8K);
            RATE_T1: period = CNT_W'(PER_T1);
            default: period = CNT_W'(PER_E1);
        endcase
    end

    // previous selection and the reserved-code flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= use_sec_i;
            rate_err_q <= 1'b0;
        end else begin
            sel_q      <= use_sec_i;
            rate_err_q <= rsvd;
        end
    end

    rpc_phase_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise_i(ref_rise),
        .fb_rise_i (rise[2]),
        .switch_i  (switch_now),
        .en_i      (corr_en_i),
        .clr_i     (corr_clr_i),
        .period_i  (period),
        .delay_o   (delay),
        .blank_o   (blank)
    );

    rpc_delay_line #(.CNT_W(CNT_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise_i(ref_rise),
        .delay_i   (delay),
        .blank_i   (blank),
        .suppress_i(rsvd),
        .vref_o    (vref_o)
    );

    // R8: reserved code raises the flag next clock
    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd |=> rate_err_o);

    // R2: with no correction, an output pulse follows a selected edge
    a_r2_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_en_i && !rsvd && ref_rise) |=> vref_o);
endmodule

// File: tb/ref_phase_corrector_tb.sv
module ref_phase_corrector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri_ref = 1'b0, sec_ref = 1'b0, use_sec = 1'b0, fb = 1'b0;
    logic       corr_en = 1'b0, corr_clr = 1'b0;
    logic [1:0] rate_sel = 2'b11;
    logic       vref, rate_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ref_phase_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .pri_ref_i(pri_ref), .sec_ref_i(sec_ref),
        .use_sec_i(use_sec), .fb_i(fb), .corr_en_i(corr_en),
        .corr_clr_i(corr_clr), .rate_sel_i(rate_sel),
        .vref_o(vref), .rate_err_o(rate_err)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        tick();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    // pulse one reference, return clocks until vref (-1 if none in 40)
    task automatic time_pulse(input bit on_sec, output int lat);
        lat = -1;
        tick();
        if (on_sec) sec_ref = 1'b1; else pri_ref = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            tick();
            if (i == 1) begin sec_ref = 1'b0; pri_ref = 1'b0; end
            if (vref && lat < 0) lat = i;
        end
    endtask

    // switch selection, then new-ref edge and feedback edge gap clocks apart;
    // clear_at_fb raises clear in the feedback cycle. Counts stray pulses.
    task automatic switch_and_measure(input int gap, input bit clear_at_fb,
                                      output int stray);
        stray = 0;
        tick();
        use_sec = ~use_sec;
        tick();
        if (vref) stray++;
        if (use_sec) sec_ref = 1'b1; else pri_ref = 1'b1;
        if (gap == 0) begin fb = 1'b1; corr_clr = clear_at_fb; end
        for (int i = 1; i <= gap; i++) begin
            tick();
            if (vref) stray++;
            if (i == 1) begin sec_ref = 1'b0; pri_ref = 1'b0; end
            if (i == gap) begin fb = 1'b1; corr_clr = clear_at_fb; end
        end
        tick();
        if (vref) stray++;
        fb = 1'b0; corr_clr = 1'b0; sec_ref = 1'b0; pri_ref = 1'b0;
        repeat (2) begin tick(); if (vref) stray++; end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pri_ref = 1'b1;
        repeat (3) tick();
        check(vref, 0, "R1 vref in reset");
        check(rate_err, 0, "R1 rate_err in reset");
        pri_ref = 1'b0;
        rst_n = 1'b1;
        repeat (2) tick();
    endtask

    task automatic t_pass();
        int lat;
        corr_en = 1'b0; use_sec = 1'b0;
        tick();
        time_pulse(1'b0, lat); check(lat, 1, "R2 selected primary");
        time_pulse(1'b1, lat); check(lat, -1, "R2 unselected secondary");
    endtask

    task automatic t_switch_noen();
        int lat;
        tick(); use_sec = 1'b1;
        time_pulse(1'b1, lat); check(lat, 1, "R3 switch without enable");
    endtask

    task automatic t_measure();
        int lat, stray;
        corr_en = 1'b1;
        switch_and_measure(4, 1'b0, stray);
        check(stray, 0, "R4 blank until measured");
        time_pulse(use_sec, lat); check(lat, 5, "R5 delay 4");
        time_pulse(use_sec, lat); check(lat, 5, "R5 delay held");
    endtask

    task automatic t_clear();
        int lat, stray;
        tick(); corr_clr = 1'b1; tick(); corr_clr = 1'b0;
        time_pulse(use_sec, lat); check(lat, 1, "R7 clear zeroes delay");
        switch_and_measure(4, 1'b1, stray);
        time_pulse(use_sec, lat); check(lat, 1, "R7 clear beats completion");
    endtask

    task automatic t_same_cycle();
        int lat, stray;
        switch_and_measure(0, 1'b0, stray);
        time_pulse(use_sec, lat); check(lat, 1, "R9 coincident edges");
    endtask

    task automatic t_modulo();
        int lat, stray;
        rate_sel = 2'b11; do_reset();
        switch_and_measure(12, 1'b0, stray);
        time_pulse(use_sec, lat); check(lat, 3, "R6 gap 12 mod 10");
        rate_sel = 2'b10; do_reset();
        switch_and_measure(12, 1'b0, stray);
        time_pulse(use_sec, lat); check(lat, 13, "R6 gap 12 mod 13");
    endtask

    task automatic t_disable();
        int lat, stray;
        rate_sel = 2'b11; do_reset();
        switch_and_measure(6, 1'b0, stray);
        time_pulse(use_sec, lat); check(lat, 7, "R10 delay before disable");
        tick(); corr_en = 1'b0;
        time_pulse(use_sec, lat); check(lat, 1, "R10 disable zeroes delay");
    endtask

    task automatic t_reserved();
        int lat;
        tick(); rate_sel = 2'b00;
        tick();
        check(rate_err, 1, "R8 flag raised");
        time_pulse(use_sec, lat); check(lat, -1, "R8 output silenced");
        rate_sel = 2'b11;
        tick();
        check(rate_err, 0, "R8 flag cleared");
        time_pulse(use_sec, lat); check(lat, 1, "R8 output restored");
    endtask

    initial begin
        t_reset();
        t_pass();
        t_switch_noen();
        t_measure();
        t_clear();
        t_same_cycle();
        t_modulo();
        t_disable();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule